// File: doc/BRIEF.md
# Tiled/Linear Image Transfer Engine

This block copies a rectangular image from one memory region to another and converts its layout on the way. Each side is stored either row-major (linear) or in 8x8 tiles whose pixels are arranged in Z (bit-interleaved) order. On request the engine halves the image width, or both width and height, by averaging neighbouring source pixels. It can also mirror the image top to bottom. Every pixel is 32 bits wide: four 8-bit channels, four bytes.

A controller places the base addresses, the dimensions, the layout flags and the scaling mode on the inputs and pulses the start input. The engine then works through the destination image on a single request-based memory port. Reads return data in the cycle after the request. The engine sets busy while it works and pulses done once at the end. A configuration that it rejects makes no memory access at all, and it still returns through done.

Top module: `dxfer_unit`

## Requirements
- R1: After reset, busy, done and the memory request are all low.
- R2: A start makes no memory access and still gives one done pulse when input width, input height, output width or output height is zero, or when the output width or height drops to zero after halving.
- R3: A start makes no memory access and still gives one done pulse when the scale code is 3, or when the scale code is nonzero and the source is linear. Scale codes: 0 = none, 1 = halve width, 2 = halve width and height.
- R4: The destination is linear when the source-linear flag equals the keep-layout flag. Otherwise it is tiled. The source is tiled whenever the source-linear flag is low.
- R5: A linear pixel sits at byte address base + 4·(x + y·w). w is the input width for the source and the effective output width for the destination.
- R6: A tiled pixel sits at byte address base + 4·(c + 8·(x with its low 3 bits cleared) + (y with its low 3 bits cleared)·w). c is the 6-bit value {y2,x2,y1,x1,y0,x0}.
- R7: With scaling, the effective output width is the output width shifted right by one. The height is halved only for code 2. The source column is x·2, and the source row is y·2 only for code 2.
- R8: Code 1 reads 2 consecutive source pixels and code 2 reads 4, starting at the source pixel address. Each 8-bit channel is the sum divided by the pixel count, truncated.
- R9: With flip set, destination row y is written to row (effective height − 1 − y). The source row is still derived from the unflipped y.
- R10: busy stays high from the cycle after an accepted start until the done cycle. done lasts one cycle and busy is low after it. A start while busy is ignored.
- R11: A transfer writes each destination pixel exactly once and makes exactly (pixel count × reads per pixel) reads. Nothing outside the destination image changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| src_base_i | input | ADDR_W | Source image byte address |
| dst_base_i | input | ADDR_W | Destination image byte address |
| in_w_i | input | DIM_W | Source width in pixels |
| in_h_i | input | DIM_W | Source height in pixels |
| out_w_i | input | DIM_W | Destination width before halving |
| out_h_i | input | DIM_W | Destination height before halving |
| src_linear_i | input | 1 | Source is row-major |
| keep_layout_i | input | 1 | Destination uses the same layout as the source |
| scale_i | input | 2 | Scale code |
| flip_i | input | 1 | Mirror rows vertically |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of access |
| mem_wdata_o | output | 32 | Write pixel |
| mem_rdata_i | input | 32 | Read pixel, valid the cycle after a read request |

## Verification
The bench builds the engine with ADDR_W = 16 and DIM_W = 6. Images up to 16 pixels on a side then fit in a 2048-word memory, so a sweep covers every layout pairing, both flip settings and both scaling modes over images one and two tiles wide and tall. At those sizes the tile-column and tile-row terms of the tiled address are both exercised. After every transfer, the full destination region is compared against an image computed arithmetically in the bench, and the read and write counts are compared with the pixel count.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;
    localparam int CH_W  = 8;
    localparam int NCH   = 4;
    localparam int PIX_W = CH_W * NCH;
    localparam int BPP   = PIX_W / 8;
    localparam int SUM_W = CH_W + 2;

    localparam logic [1:0] SC_NONE = 2'd0;
    localparam logic [1:0] SC_X    = 2'd1;
    localparam logic [1:0] SC_XY   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_ACC,
        ST_WRITE,
        ST_DONE
    } st_e;

    // Z-order position of a pixel inside an 8x8 tile
    function automatic logic [5:0] tile_code(input logic [2:0] x, input logic [2:0] y);
        return {y[2], x[2], y[1], x[1], y[0], x[0]};
    endfunction
endpackage

// File: rtl/dxfer_addr_gen.sv
module dxfer_addr_gen
    import dxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 10
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DIM_W-1:0]  x_i,
    input  logic [DIM_W-1:0]  y_i,
    input  logic [DIM_W-1:0]  stride_i,
    input  logic              tiled_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BPP_SH = $clog2(BPP);

    logic [ADDR_W-1:0] xw, yw, sw, x_hi, y_hi, pix_lin, pix_til, pix;

    always_comb begin
        xw      = ADDR_W'(x_i);
        yw      = ADDR_W'(y_i);
        sw      = ADDR_W'(stride_i);
        x_hi    = xw & ~ADDR_W'(7);
        y_hi    = yw & ~ADDR_W'(7);
        pix_lin = xw + yw * sw;
        pix_til = ADDR_W'(tile_code(x_i[2:0], y_i[2:0])) + (x_hi << 3) + y_hi * sw;
        pix     = tiled_i ? pix_til : pix_lin;
        addr_o  = base_i + (pix << BPP_SH);
    end
endmodule

// File: rtl/dxfer_box_avg.sv
module dxfer_box_avg
    import dxfer_pkg::*;
(
    input  logic [NCH-1:0][SUM_W-1:0] sum_i,
    input  logic [1:0]                shift_i,
    output logic [PIX_W-1:0]          pix_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SUM_W-1:0] avg;
        assign avg = sum_i[c] >> shift_i;
        assign pix_o[c*CH_W +: CH_W] = avg[CH_W-1:0];
    end
endmodule

// File: rtl/dxfer_unit.sv
module dxfer_unit
    import dxfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_base_i,
    input  logic [ADDR_W-1:0] dst_base_i,
    input  logic [DIM_W-1:0]  in_w_i,
    input  logic [DIM_W-1:0]  in_h_i,
    input  logic [DIM_W-1:0]  out_w_i,
    input  logic [DIM_W-1:0]  out_h_i,
    input  logic              src_linear_i,
    input  logic              keep_layout_i,
    input  logic [1:0]        scale_i,
    input  logic              flip_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [PIX_W-1:0]  mem_wdata_o,
    input  logic [PIX_W-1:0]  mem_rdata_i
);
    localparam int BPP_SH = $clog2(BPP);

    typedef struct packed {
        st_e                      st;
        logic [ADDR_W-1:0]        src;
        logic [ADDR_W-1:0]        dst;
        logic [DIM_W-1:0]         in_w;
        logic [DIM_W-1:0]         ow;
        logic [DIM_W-1:0]         oh;
        logic                     src_tiled;
        logic                     dst_tiled;
        logic                     flip;
        logic                     hs;
        logic                     vs;
        logic [DIM_W-1:0]         x;
        logic [DIM_W-1:0]         y;
        logic [1:0]               k;
        logic [NCH-1:0][SUM_W-1:0] acc;
    } regs_t;

    regs_t r_d, r_q;

    // start-time decode
    logic             hs_in, vs_in, cfg_ok;
    logic [DIM_W-1:0] ow_in, oh_in;

    always_comb begin
        hs_in  = (scale_i != SC_NONE);
        vs_in  = (scale_i == SC_XY);
        ow_in  = out_w_i >> hs_in;
        oh_in  = out_h_i >> vs_in;
        cfg_ok = (in_w_i != '0) && (in_h_i != '0) && (out_w_i != '0) && (out_h_i != '0)
               && (ow_in != '0) && (oh_in != '0)
               && (scale_i <= SC_XY)
               && !(src_linear_i && hs_in);
    end

    // coordinates of the current pixel
    logic [DIM_W-1:0]  ix, iy, oy;
    logic [ADDR_W-1:0] src_pix_addr, dst_pix_addr;
    logic [1:0]        k_last;

    always_comb begin
        ix     = r_q.hs ? {r_q.x[DIM_W-2:0], 1'b0} : r_q.x;
        iy     = r_q.vs ? {r_q.y[DIM_W-2:0], 1'b0} : r_q.y;
        oy     = r_q.flip ? (r_q.oh - DIM_W'(1) - r_q.y) : r_q.y;
        k_last = {r_q.vs, r_q.hs};
    end

    dxfer_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_src_addr (
        .base_i  (r_q.src),
        .x_i     (ix),
        .y_i     (iy),
        .stride_i(r_q.in_w),
        .tiled_i (r_q.src_tiled),
        .addr_o  (src_pix_addr)
    );

    dxfer_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dst_addr (
        .base_i  (r_q.dst),
        .x_i     (r_q.x),
        .y_i     (oy),
        .stride_i(r_q.ow),
        .tiled_i (r_q.dst_tiled),
        .addr_o  (dst_pix_addr)
    );

    dxfer_box_avg u_avg (
        .sum_i  (r_q.acc),
        .shift_i({1'b0, r_q.hs} + {1'b0, r_q.vs}),
        .pix_o  (mem_wdata_o)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.src       = src_base_i;
                    r_d.dst       = dst_base_i;
                    r_d.in_w      = in_w_i;
                    r_d.ow        = ow_in;
                    r_d.oh        = oh_in;
                    r_d.src_tiled = !src_linear_i;
                    r_d.dst_tiled = (src_linear_i != keep_layout_i);
                    r_d.flip      = flip_i;
                    r_d.hs        = hs_in;
                    r_d.vs        = vs_in;
                    r_d.x         = '0;
                    r_d.y         = '0;
                    r_d.k         = '0;
                    r_d.acc       = '0;
                    r_d.st        = cfg_ok ? ST_READ : ST_DONE;
                end
            end
            ST_READ: r_d.st = ST_ACC;
            ST_ACC: begin
                for (int c = 0; c < NCH; c++) begin
                    r_d.acc[c] = r_q.acc[c] + SUM_W'(mem_rdata_i[c*CH_W +: CH_W]);
                end
                if (r_q.k == k_last) begin
                    r_d.st = ST_WRITE;
                end else begin
                    r_d.k  = r_q.k + 2'd1;
                    r_d.st = ST_READ;
                end
            end
            ST_WRITE: begin
                r_d.acc = '0;
                r_d.k   = '0;
                r_d.st  = ST_READ;
                if (r_q.x == r_q.ow - DIM_W'(1)) begin
                    r_d.x = '0;
                    if (r_q.y == r_q.oh - DIM_W'(1)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.y = r_q.y + DIM_W'(1);
                    end
                end else begin
                    r_d.x = r_q.x + DIM_W'(1);
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy_o     = (r_q.st != ST_IDLE);
        done_o     = (r_q.st == ST_DONE);
        mem_req_o  = (r_q.st == ST_READ) || (r_q.st == ST_WRITE);
        mem_we_o   = (r_q.st == ST_WRITE);
        mem_addr_o = mem_we_o ? dst_pix_addr
                              : src_pix_addr + (ADDR_W'(r_q.k) << BPP_SH);
    end

    // R10: done is followed by idle
    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R10: a start while busy leaves the captured configuration alone
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.src) && $stable(r_q.ow) && $stable(r_q.oh)));

    // R2 / R3: a rejected start goes straight to done with no access
    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !cfg_ok) |=> (done_o && !mem_req_o));

    // R8: read index stays within the pixels of the box
    p_read_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACC) |-> (r_q.k <= k_last));

    // R11: every write lands inside the destination image
    p_write_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ((r_q.x < r_q.ow) && (r_q.y < r_q.oh)));
endmodule

// File: tb/dxfer_unit_test.sv
module dxfer_unit_test;
    localparam int ADDR_W = 16;
    localparam int DIM_W  = 6;
    localparam int WORDS  = 2048;
    localparam int DSTW   = 1024;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] src_base_i = '0;
    logic [ADDR_W-1:0] dst_base_i = 16'h1000;
    logic [DIM_W-1:0]  in_w_i = '0, in_h_i = '0, out_w_i = '0, out_h_i = '0;
    logic              src_linear_i = 1'b0, keep_layout_i = 1'b0, flip_i = 1'b0;
    logic [1:0]        scale_i = '0;
    logic              busy_o, done_o, mem_req_o, mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [31:0]       mem_wdata_o;
    logic [31:0]       mem_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    logic load_req = 1'b0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] mem [0:WORDS-1];
    logic [31:0] exp_img [0:DSTW-1];

    always #10 clk = ~clk;

    dxfer_unit #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i),
        .in_w_i(in_w_i), .in_h_i(in_h_i), .out_w_i(out_w_i), .out_h_i(out_h_i),
        .src_linear_i(src_linear_i), .keep_layout_i(keep_layout_i),
        .scale_i(scale_i), .flip_i(flip_i),
        .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    function automatic logic [31:0] pat(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b * 8'd37 ^ 8'h3C, b + i[9:2], ~b, b * 8'd5 + {6'd0, i[9:8]}};
    endfunction

    function automatic int tile_pix(input int x, input int y, input int w);
        int c;
        c = (x & 1) | ((y & 1) << 1) | (((x >> 1) & 1) << 2) | (((y >> 1) & 1) << 3)
          | (((x >> 2) & 1) << 4) | (((y >> 2) & 1) << 5);
        return c + (x / 8) * 64 + (y / 8) * 8 * w;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= (i < DSTW) ? pat(i) : SENT;
        end else if (mem_req_o) begin
            if (mem_we_o) begin
                mem[mem_addr_o[12:2]] <= mem_wdata_o;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata_i <= mem[mem_addr_o[12:2]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic run(input bit lin, input bit keep, input bit flp, input int sc,
                       input int iw, input int ih, input int ow, input int oh,
                       input bit poke, input string req);
        int r0, w0, cyc, hs, vs, ew, eh, n, mism, first_bad, first_act, first_exp;
        bit ok, seen;
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
        r0 = rd_cnt; w0 = wr_cnt;
        src_linear_i = lin; keep_layout_i = keep; flip_i = flp; scale_i = 2'(sc);
        in_w_i = DIM_W'(iw); in_h_i = DIM_W'(ih); out_w_i = DIM_W'(ow); out_h_i = DIM_W'(oh);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        cyc = 0; seen = 1'b0;
        while (!seen && cyc < 5000) begin
            if (done_o) seen = 1'b1;
            else begin
                if (poke && cyc == 3) begin
                    start_i = 1'b1; out_w_i = DIM_W'(2); flip_i = ~flp;
                end
                @(negedge clk);
                if (poke && cyc == 3) begin
                    start_i = 1'b0; out_w_i = DIM_W'(ow); flip_i = flp;
                end
                cyc++;
            end
        end
        check("R10", {req, " done pulse"}, int'(seen), 1);
        @(negedge clk);
        check("R10", {req, " idle after done"}, int'(busy_o || done_o), 0);

        // expected image
        hs = (sc != 0) ? 1 : 0;
        vs = (sc == 2) ? 1 : 0;
        ew = ow >> hs; eh = oh >> vs; n = 1 << (hs + vs);
        ok = iw != 0 && ih != 0 && ow != 0 && oh != 0 && ew != 0 && eh != 0
             && sc <= 2 && !(lin && sc != 0);
        for (int i = 0; i < DSTW; i++) exp_img[i] = SENT;
        if (ok) begin
            for (int y = 0; y < eh; y++) begin
                for (int x = 0; x < ew; x++) begin
                    int sp, dp, oyv, ix, iy;
                    logic [31:0] px;
                    ix = x << hs; iy = y << vs;
                    oyv = flp ? (eh - 1 - y) : y;
                    sp = lin ? (ix + iy * iw) : tile_pix(ix, iy, iw);
                    dp = (lin == keep) ? (x + oyv * ew) : tile_pix(x, oyv, ew);
                    for (int c = 0; c < 4; c++) begin
                        int s;
                        s = 0;
                        for (int k = 0; k < n; k++) s += int'(pat(sp + k) >> (8 * c)) & 255;
                        px[8*c +: 8] = 8'(s >> (hs + vs));
                    end
                    exp_img[dp] = px;
                end
            end
        end
        mism = 0; first_bad = -1; first_act = 0; first_exp = 0;
        for (int i = 0; i < DSTW; i++) begin
            if (mem[DSTW + i] !== exp_img[i]) begin
                if (mism == 0) begin
                    first_bad = i; first_act = int'(mem[DSTW + i]); first_exp = int'(exp_img[i]);
                end
                mism++;
            end
        end
        checks++;
        if (mism != 0) begin
            errors++;
            $display("FAIL %s image word %0d: actual %08h expected %08h (%0d bad)",
                     req, first_bad, first_act, first_exp, mism);
        end
        check(ok ? "R11" : req, {req, " reads"}, rd_cnt - r0, ok ? ew * eh * n : 0);
        check(ok ? "R11" : req, {req, " writes"}, wr_cnt - w0, ok ? ew * eh : 0);
    endtask

    initial begin
        #(20 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #35;
        check("R1", "busy at reset", int'(busy_o), 0);
        check("R1", "done at reset", int'(done_o), 0);
        check("R1", "mem_req at reset", int'(mem_req_o), 0);
        @(negedge clk) rst_n = 1'b1;

        // R4 R5 R6 R9: all layout pairings, flips, several shapes
        for (int lin = 0; lin < 2; lin++)
            for (int keep = 0; keep < 2; keep++)
                for (int f = 0; f < 2; f++) begin
                    run(lin[0], keep[0], f[0], 0, 8, 8, 8, 8, 1'b0, "R4 R5 R6 R9 8x8");
                    run(lin[0], keep[0], f[0], 0, 16, 8, 16, 8, 1'b0, "R4 R5 R6 R9 16x8");
                    run(lin[0], keep[0], f[0], 0, 8, 16, 8, 16, 1'b0, "R4 R5 R6 R9 8x16");
                end

        // R7 R8: halving with tiled source
        for (int keep = 0; keep < 2; keep++)
            for (int f = 0; f < 2; f++)
                for (int sc = 1; sc < 3; sc++) begin
                    run(1'b0, keep[0], f[0], sc, 8, 8, 8, 8, 1'b0, "R7 R8 8x8");
                    run(1'b0, keep[0], f[0], sc, 16, 16, 16, 16, 1'b0, "R7 R8 16x16");
                end

        // R10: start while busy is ignored
        run(1'b1, 1'b1, 1'b0, 0, 8, 8, 8, 8, 1'b1, "R10 restart ignored");
        run(1'b0, 1'b0, 1'b1, 2, 16, 16, 16, 16, 1'b1, "R10 restart ignored scaled");

        // R2: zero dimensions
        run(1'b0, 1'b0, 1'b0, 0, 0, 8, 8, 8, 1'b0, "R2 in_w zero");
        run(1'b0, 1'b0, 1'b0, 0, 8, 0, 8, 8, 1'b0, "R2 in_h zero");
        run(1'b0, 1'b0, 1'b0, 0, 8, 8, 0, 8, 1'b0, "R2 out_w zero");
        run(1'b0, 1'b0, 1'b0, 0, 8, 8, 8, 0, 1'b0, "R2 out_h zero");
        run(1'b0, 1'b0, 1'b0, 1, 8, 8, 1, 8, 1'b0, "R2 width halved to zero");
        run(1'b0, 1'b0, 1'b0, 2, 8, 8, 8, 1, 1'b0, "R2 height halved to zero");
        // R3: bad scale settings
        run(1'b0, 1'b0, 1'b0, 3, 8, 8, 8, 8, 1'b0, "R3 scale code 3");
        run(1'b1, 1'b0, 1'b0, 1, 8, 8, 8, 8, 1'b0, "R3 linear with scaling");
        run(1'b1, 1'b1, 1'b0, 2, 8, 8, 8, 8, 1'b0, "R3 linear with XY scaling");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule